// File: doc/BRIEF.md
# Smart Fault Shutdown Sequencer

This block sequences the fault shutdown of a half-bridge gate driver. A synchronous trip from a fault comparator turns off every gate output on the next clock edge. It then pulls down a shared active-low shutdown line through an open-drain enable and keeps that pull-down on. The block itself never waits for the line to fall. The pull-down stays on until the line is seen below a low unlatch level. At that point it lets go, and an external pull-up recharges the line through an RC network. The gates remain off until the line is seen above the normal logic-high level. After that, the gate outputs follow their command inputs again.

The shared line is presented as two digital flags: one for above the logic-high threshold and one for below the unlatch threshold. These flags can pass through an optional synchronizer chain. Outside of a fault, an external low on the line blocks the gates only while it lasts, so the line can be used for PWM chopping. While supply undervoltage lockout is active, the fault trip is ignored. A one-cycle event pulse marks each entry into the pull-down state.

Top module: `fsd_ctrl`

## Requirements
- R1: After reset, all gate outputs are 0, the pull-down enable is 0 and the fault event pulse is 0.
- R2: A fault trip sampled with lockout inactive forces every gate output to 0 on the next cycle, whatever the line flags show.
- R3: Once asserted by a fault, the pull-down enable stays 1 for every cycle in which the unlatch flag has not been seen.
- R4: While the pull-down is on, the unlatch flag seen at a clock edge turns the pull-down off on the following cycle.
- R5: After the pull-down is released, gate outputs stay 0 until the line-high flag is seen. At that edge the outputs take the command value.
- R6: Outside a fault, gate outputs are 0 for each cycle after the line-high flag was low. They return to the command value the cycle after it is high again. The low is not latched: the pull-down stays off, even if the unlatch flag is also seen.
- R7: While lockout is active, a fault trip produces no pull-down, no event pulse and no change to the gate outputs.
- R8: A fault trip during the recovery wait, with the pull-down released, returns the block to the pull-down state. The pull-down turns back on and a new event pulse is produced.
- R9: The fault event pulse is exactly one cycle wide. It appears only on entry into the pull-down state, and never while the pull-down state is held.
- R10: In normal operation with the line high, each gate output equals its command bit sampled at the previous edge (bit i drives gate i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| fault_i | input | 1 | Synchronous fault comparator trip |
| line_hi_i | input | 1 | Shutdown line above logic-high threshold |
| line_lo_i | input | 1 | Shutdown line below unlatch threshold |
| cmd_i | input | NUM_GATES | Gate command bits from the controller |
| drv_o | output | NUM_GATES | Gate drive outputs |
| pd_en_o | output | 1 | Open-drain pull-down enable for the shutdown line |
| fault_evt_o | output | 1 | One-cycle pulse on entry to the pull-down state |

## Verification
The bench builds the block with NUM_GATES = 2 and LINE_SYNC = 0. Because the line flags then act on the next edge, the cycle exact timing of release, re-arm and chopping is visible at the ports. Two gates are enough to show that each output follows its own command bit and that all outputs drop together on a trip. A final phase closes the loop with a cycle-counted RC model of the line, driven by the pull-down output, and confirms the full discharge, release and recharge sequence.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RECOVER = 2'd2
   } fsd_state_e;
endpackage

// File: rtl/fsd_line_sync.sv
module fsd_line_sync #(
   parameter int STAGES = 0,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else if (s == 0) stg_q[s] <= d_i;
            else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
         end
      end
      assign q_o = stg_q[STAGES-1];
   end
endmodule

// File: rtl/fsd_fault_qual.sv
module fsd_fault_qual (
   input  logic fault_i,
   input  logic uvlo_i,
   output logic trip_o
);
   // comparator is blind while the supply is locked out
   always_comb trip_o = fault_i & ~uvlo_i;
endmodule

// File: rtl/fsd_seq.sv
module fsd_seq
   import fsd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip_i,
   input  logic       line_hi_i,
   input  logic       line_lo_i,
   output fsd_state_e state_o,
   output logic       gate_en_nx_o,
   output logic       pd_en_o,
   output logic       evt_o
);
   fsd_state_e state_q, state_nx;
   logic       pd_q, evt_q;

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         ST_RUN:     if (trip_i) state_nx = ST_HOLD;
         ST_HOLD:    if (line_lo_i) state_nx = ST_RECOVER;
         ST_RECOVER: begin
            if (trip_i) state_nx = ST_HOLD;
            else if (line_hi_i) state_nx = ST_RUN;
         end
         default:    state_nx = ST_HOLD;
      endcase
   end

   // direct path: gates enabled only when staying in RUN with the line high
   always_comb gate_en_nx_o = (state_nx == ST_RUN) && line_hi_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         pd_q    <= 1'b0;
         evt_q   <= 1'b0;
      end else begin
         state_q <= state_nx;
         pd_q    <= (state_nx == ST_HOLD);
         evt_q   <= (state_nx == ST_HOLD) && (state_q != ST_HOLD);
      end
   end

   assign state_o = state_q;
   assign pd_en_o = pd_q;
   assign evt_o   = evt_q;
endmodule

// File: rtl/fsd_gate_stage.sv
module fsd_gate_stage #(
   parameter int NUM_GATES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_nx_i,
   input  logic [NUM_GATES-1:0] cmd_i,
   output logic [NUM_GATES-1:0] drv_o
);
   for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      logic drv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q <= 1'b0;
         else drv_q <= en_nx_i & cmd_i[g];
      end
      assign drv_o[g] = drv_q;
   end
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
   import fsd_pkg::*;
#(
   parameter int NUM_GATES = 2,
   parameter int LINE_SYNC = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 uvlo_i,
   input  logic                 fault_i,
   input  logic                 line_hi_i,
   input  logic                 line_lo_i,
   input  logic [NUM_GATES-1:0] cmd_i,
   output logic [NUM_GATES-1:0] drv_o,
   output logic                 pd_en_o,
   output logic                 fault_evt_o
);
   localparam int FLAG_W = 2;

   if (NUM_GATES < 1 || NUM_GATES > 64) begin : g_bad_gates
      $error("fsd_ctrl: NUM_GATES must lie in 1..64");
   end
   if (LINE_SYNC < 0 || LINE_SYNC > 4) begin : g_bad_sync
      $error("fsd_ctrl: LINE_SYNC must lie in 0..4");
   end

   logic [FLAG_W-1:0] flags_s;
   logic              line_hi_s, line_lo_s;
   logic              trip;
   logic              gate_en_nx;
   fsd_state_e        state;

   fsd_line_sync #(.STAGES(LINE_SYNC), .WIDTH(FLAG_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({line_hi_i, line_lo_i}),
      .q_o   (flags_s)
   );
   assign line_hi_s = flags_s[1];
   assign line_lo_s = flags_s[0];

   fsd_fault_qual u_qual (
      .fault_i (fault_i),
      .uvlo_i  (uvlo_i),
      .trip_o  (trip)
   );

   fsd_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .trip_i       (trip),
      .line_hi_i    (line_hi_s),
      .line_lo_i    (line_lo_s),
      .state_o      (state),
      .gate_en_nx_o (gate_en_nx),
      .pd_en_o      (pd_en_o),
      .evt_o        (fault_evt_o)
   );

   fsd_gate_stage #(.NUM_GATES(NUM_GATES)) u_gates (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_nx_i (gate_en_nx),
      .cmd_i   (cmd_i),
      .drv_o   (drv_o)
   );
endmodule

// File: rtl/fsd_ctrl_chk.sv
module fsd_ctrl_chk #(
   parameter int NUM_GATES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 uvlo_i,
   input logic                 fault_i,
   input logic                 line_hi_s,
   input logic                 line_lo_s,
   input logic [NUM_GATES-1:0] drv_o,
   input logic                 pd_en_o,
   input logic                 fault_evt_o
);
   // R2
   trip_kills_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_i && !uvlo_i) |=> (drv_o == '0));
   // R3
   pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_en_o && !line_lo_s) |=> pd_en_o);
   // R4
   pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_en_o && line_lo_s) |=> !pd_en_o);
   // R6
   line_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_hi_s |=> (drv_o == '0));
   // R7
   uvlo_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> !fault_evt_o);
   // R9
   event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt_o |=> !fault_evt_o);
   // R9
   event_with_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt_o |-> pd_en_o);
endmodule

bind fsd_ctrl fsd_ctrl_chk #(.NUM_GATES(NUM_GATES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .uvlo_i      (uvlo_i),
   .fault_i     (fault_i),
   .line_hi_s   (line_hi_s),
   .line_lo_s   (line_lo_s),
   .drv_o       (drv_o),
   .pd_en_o     (pd_en_o),
   .fault_evt_o (fault_evt_o)
);

// File: tb/test_fsd_ctrl.sv
module test_fsd_ctrl;
   localparam int NG = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          uvlo = 1'b0, fault = 1'b0, hi = 1'b1, lo = 1'b0;
   logic [NG-1:0] cmd = '0;
   logic [NG-1:0] drv;
   logic          pd, evt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [NG-1:0] drv;
      logic          pd;
      logic          evt;
      string         req;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   fsd_ctrl #(.NUM_GATES(NG), .LINE_SYNC(0)) i_fsd_ctrl (
      .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .fault_i(fault),
      .line_hi_i(hi), .line_lo_i(lo), .cmd_i(cmd),
      .drv_o(drv), .pd_en_o(pd), .fault_evt_o(evt)
   );

   task automatic check(input string req, input logic [NG-1:0] d,
                        input logic p, input logic e);
      total++;
      if (drv !== d || pd !== p || evt !== e) begin
         bad++;
         $display("FAIL %s: drv=%b pd=%b evt=%b expected drv=%b pd=%b evt=%b",
                  req, drv, pd, evt, d, p, e);
      end
   endtask

   // monitor: compares after each edge that has a pending item
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         check(it.req, it.drv, it.pd, it.evt);
      end
   end

   task automatic step(input logic f, input logic u, input logic h, input logic l,
                       input logic [NG-1:0] c, input logic [NG-1:0] ed,
                       input logic ep, input logic ee, input string req);
      exp_t it;
      @(negedge clk);
      fault = f; uvlo = u; hi = h; lo = l; cmd = c;
      it.drv = ed; it.pd = ep; it.evt = ee; it.req = req;
      exp_q.push_back(it);
   endtask

   initial begin
      #(8 * 50000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1", '0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", '0, 1'b0, 1'b0);

      // R10 following commands
      step(0,0,1,0,2'b01, 2'b01,0,0,"R10");
      step(0,0,1,0,2'b10, 2'b10,0,0,"R10");
      step(0,0,1,0,2'b11, 2'b11,0,0,"R10");
      // R6 external chopping, not latched
      step(0,0,0,0,2'b11, 2'b00,0,0,"R6");
      step(0,0,0,1,2'b11, 2'b00,0,0,"R6");
      step(0,0,1,0,2'b11, 2'b11,0,0,"R6");
      // R7 lockout masks trip
      step(1,1,1,0,2'b11, 2'b11,0,0,"R7");
      step(0,0,1,0,2'b11, 2'b11,0,0,"R7");
      // R2 trip with line high
      step(1,0,1,0,2'b11, 2'b00,1,1,"R2");
      step(0,0,1,0,2'b11, 2'b00,1,0,"R9");
      step(1,0,0,0,2'b11, 2'b00,1,0,"R3");
      step(0,0,0,0,2'b11, 2'b00,1,0,"R3");
      step(0,0,0,1,2'b11, 2'b00,0,0,"R4");
      step(0,0,0,0,2'b11, 2'b00,0,0,"R5");
      step(0,0,0,1,2'b11, 2'b00,0,0,"R5");
      step(0,0,1,0,2'b10, 2'b10,0,0,"R5");
      // R8 re-trip during recovery
      step(1,0,1,0,2'b11, 2'b00,1,1,"R2");
      step(0,0,0,1,2'b11, 2'b00,0,0,"R4");
      step(1,0,0,0,2'b11, 2'b00,1,1,"R8");
      step(0,0,1,0,2'b11, 2'b00,1,0,"R8");
      step(0,0,0,1,2'b11, 2'b00,0,0,"R4");
      // R7 lockout during recovery
      step(1,1,0,0,2'b11, 2'b00,0,0,"R7");
      step(0,0,1,0,2'b01, 2'b01,0,0,"R5");
      step(0,0,1,0,2'b01, 2'b01,0,0,"R10");
      @(negedge clk);
      while (exp_q.size() > 0) @(negedge clk);

      // closed loop with RC model: level 0..100, hi>=70, lo<=20
      begin
         int v = 100;
         int hold_cyc = 0;
         bit released = 1'b0;
         bit back = 1'b0;
         bit leak = 1'b0;
         cmd = 2'b11;
         fault = 1'b1;
         @(negedge clk);
         fault = 1'b0;
         for (int n = 0; n < 400 && !back; n++) begin
            if (pd) begin
               v = (v > 5) ? v - 5 : 0;
               hold_cyc++;
            end else begin
               v = (v < 98) ? v + 2 : 100;
               if (hold_cyc > 0) released = 1'b1;
            end
            hi = (v >= 70);
            lo = (v <= 20);
            @(posedge clk); #2;
            if (drv == 2'b11) back = 1'b1;
            else if (drv != '0) leak = 1'b1;
            @(negedge clk);
         end
         total++;
         if (!released) begin
            bad++;
            $display("FAIL R4: released=%0b expected=1", released);
         end
         total++;
         if (!back || leak) begin
            bad++;
            $display("FAIL R5: back=%0b leak=%0b expected back=1 leak=0", back, leak);
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule